// File: doc/BRIEF.md
# Interleaving Address Section Decoder

This block steers 32-bit system addresses onto one of two memory controller ports. A small bank of section registers, loaded through a simple write port, each describes one window of the system map: where it starts, how large it is, which controllers serve it, whether traffic alternates between the two controllers on 128-byte boundaries, and where the window lands inside the controller's own address range. For each request the decoder finds the covering section, chooses the controller and produces the controller-local address.

Overlapping windows are settled in favour of the highest-numbered section. This lets a wide, low-priority catch-all window send stray traffic to a controller, while a narrower, higher-numbered section describes the memory that is really present. An address that no enabled section covers is never dropped. It comes back as an error response through the same valid/ready output and does not hold up the port.

Requests use a valid/ready handshake. The result is registered one cycle after acceptance and stays in place until the downstream side takes it.

Top module: `secdec_top`

## Requirements
- R1: After reset every section register is zero, `rspValid` is low and `reqReady` is high, so any request is answered with an error.
- R2: A section register holds the window start in bits [31:24] (placed at address bits [31:24]), a size code in [22:20] meaning 16 MB shifted left by the code (code 7 is 2 GB), an interleave mode in [19:18], a controller map in [9:8] and a controller-side base in [7:0]. The section covers addresses from its start up to, but not including, start plus size.
- R3: A section register that holds all zeros is disabled and covers nothing.
- R4: When several enabled sections cover an address, the one with the highest index decides the routing.
- R5: With interleave mode 1 and controller map 3, address bit 7 selects the controller (`rspSel`). The local address is the section offset with bit 7 removed, the bits above it shifted down by one, plus the controller-side base placed at local bits [31:24].
- R6: Without that combination, map 1 selects controller 0, map 2 selects controller 1, and map 3 selects controller 0. The local address is the section offset plus the controller-side base at bits [31:24]. Map 0 yields an error.
- R7: A request that no enabled section covers is accepted and answered with `rspErr` high, `rspSel` low and `rspAddr` zero, under the same handshake as any other request.
- R8: A response stays valid and unchanged until `rspReady` is high. A new request is accepted only while the output register is empty or is being drained in that same cycle.
- R9: A section write takes effect for requests accepted in later cycles only. A request accepted in the same cycle as the write uses the old contents, and a response already held is not altered.
- R10: A 2 GB section starting at 0x80000000 covers addresses up to 0xFFFFFFFF without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Section register write strobe |
| cfgIdx | input | 2 | Index of the section register to write |
| cfgData | input | 32 | Section register contents to write |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | 32 | System address of the request |
| rspValid | output | 1 | Response valid |
| rspReady | input | 1 | Downstream takes the response |
| rspSel | output | 1 | Target controller, 0 or 1 |
| rspAddr | output | 32 | Controller-local address |
| rspErr | output | 1 | Address covered by no usable section |

## Verification
The bench builds the decoder with its default parameters: four sections, 32-bit addresses, a 16 MB size granule and interleaving on address bit 7. With these values the largest size code spans 2 GB. A window at 0x80000000 therefore runs exactly to the top of the address space, which exercises the carry bit of the offset subtraction. Four sections are also enough to stack a catch-all window, a real-memory window and two overlapping small windows, so that priority, disabling and the section boundaries can all be tested in one configuration.

// File: rtl/secdec_pkg.sv
package secdec_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // request taken this cycle: load output register
    logic drain;    // held response consumed this cycle
  } ctrlStrobes_t;

  // section register field positions (decoded by the datapath)
  localparam int BASE_HI   = 31;
  localparam int BASE_LO   = 24;
  localparam int SIZE_HI   = 22;
  localparam int SIZE_LO   = 20;
  localparam int MODE_HI   = 19;
  localparam int MODE_LO   = 18;
  localparam int MAP_HI    = 9;
  localparam int MAP_LO    = 8;
  localparam int CBASE_HI  = 7;
  localparam int CBASE_LO  = 0;

  localparam logic [1:0] MODE_INTL128 = 2'd1;
  localparam logic [1:0] MAP_NONE     = 2'd0;
  localparam logic [1:0] MAP_SECOND   = 2'd2;
  localparam logic [1:0] MAP_BOTH     = 2'd3;
endpackage

// File: rtl/secdec_ctrl.sv
module secdec_ctrl
  import secdec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         rspReady,
  output logic         rspValid,
  output ctrlStrobes_t strobes
);
  logic validQ;

  assign reqReady       = !validQ || rspReady;
  assign strobes.accept = reqValid && reqReady;
  assign strobes.drain  = validQ && rspReady;
  assign rspValid       = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)               validQ <= 1'b0;
    else if (strobes.accept) validQ <= 1'b1;
    else if (strobes.drain)  validQ <= 1'b0;
  end
endmodule

// File: rtl/secdec_dp.sv
module secdec_dp
  import secdec_pkg::*;
#(
  parameter int NUM_SEC  = 4,
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG  = 24,
  parameter int INTL_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_SEC)-1:0] cfgIdx,
  input  logic [31:0]                cfgData,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  ctrlStrobes_t               strobes,
  output logic                       rspSel,
  output logic [ADDR_W-1:0]          rspAddr,
  output logic                       rspErr
);
  localparam int BASE_SHIFT = ADDR_W - 8;

  logic [31:0]       secReg [NUM_SEC];
  logic [NUM_SEC-1:0] secHit;
  logic [ADDR_W-1:0] secOff [NUM_SEC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEC; i++) secReg[i] <= '0;
    end else if (cfgWe) begin
      secReg[cfgIdx] <= cfgData;
    end
  end

  // per-section window test
  for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
    logic [ADDR_W:0] diff;
    logic [2:0]      sizeCode;
    assign diff     = {1'b0, reqAddr} - {1'b0, secReg[g][BASE_HI:BASE_LO], {BASE_SHIFT{1'b0}}};
    assign sizeCode = secReg[g][SIZE_HI:SIZE_LO];
    assign secOff[g] = diff[ADDR_W-1:0];
    assign secHit[g] = (secReg[g] != '0) && !diff[ADDR_W] &&
                       ((diff[ADDR_W-1:0] >> (MIN_LOG + int'(sizeCode))) == '0);
  end

  // highest index wins
  logic              anyHit;
  logic [31:0]       hitReg;
  logic [ADDR_W-1:0] hitOff;
  always_comb begin
    anyHit = 1'b0;
    hitReg = '0;
    hitOff = '0;
    for (int i = 0; i < NUM_SEC; i++) begin
      if (secHit[i]) begin
        anyHit = 1'b1;
        hitReg = secReg[i];
        hitOff = secOff[i];
      end
    end
  end

  logic [1:0]        mapSel;
  logic              intlOn;
  logic              nextErr;
  logic              nextSel;
  logic [ADDR_W-1:0] adjOff;
  logic [ADDR_W-1:0] nextAddr;
  logic              unusedBits;

  assign mapSel  = hitReg[MAP_HI:MAP_LO];
  assign intlOn  = (hitReg[MODE_HI:MODE_LO] == MODE_INTL128) && (mapSel == MAP_BOTH);
  assign nextErr = !anyHit || (mapSel == MAP_NONE);
  assign nextSel = intlOn ? reqAddr[INTL_BIT] : (mapSel == MAP_SECOND);
  assign adjOff  = intlOn ? (((hitOff >> (INTL_BIT + 1)) << INTL_BIT) |
                             (hitOff & ADDR_W'((1 << INTL_BIT) - 1)))
                          : hitOff;
  assign nextAddr = {hitReg[CBASE_HI:CBASE_LO], {BASE_SHIFT{1'b0}}} + adjOff;
  assign unusedBits = ^{hitReg[23], hitReg[17:10]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspSel  <= 1'b0;
      rspAddr <= '0;
      rspErr  <= 1'b0;
    end else if (strobes.accept) begin
      rspErr  <= nextErr;
      rspSel  <= nextErr ? 1'b0 : nextSel;
      rspAddr <= nextErr ? '0 : nextAddr;
    end
  end
endmodule

// File: rtl/secdec_top.sv
module secdec_top
  import secdec_pkg::*;
#(
  parameter int NUM_SEC  = 4,
  parameter int ADDR_W   = 32,
  parameter int MIN_LOG  = 24,
  parameter int INTL_BIT = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_SEC)-1:0] cfgIdx,
  input  logic [31:0]                cfgData,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [ADDR_W-1:0]          reqAddr,
  output logic                       rspValid,
  input  logic                       rspReady,
  output logic                       rspSel,
  output logic [ADDR_W-1:0]          rspAddr,
  output logic                       rspErr
);
  ctrlStrobes_t strobes;

  secdec_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .rspReady (rspReady),
    .rspValid (rspValid),
    .strobes  (strobes)
  );

  secdec_dp #(
    .NUM_SEC  (NUM_SEC),
    .ADDR_W   (ADDR_W),
    .MIN_LOG  (MIN_LOG),
    .INTL_BIT (INTL_BIT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgIdx  (cfgIdx),
    .cfgData (cfgData),
    .reqAddr (reqAddr),
    .strobes (strobes),
    .rspSel  (rspSel),
    .rspAddr (rspAddr),
    .rspErr  (rspErr)
  );
endmodule

// File: rtl/secdec_checker.sv
module secdec_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspReady,
  input logic              rspSel,
  input logic              rspErr,
  input logic [ADDR_W-1:0] rspAddr
);
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspAddr) && $stable(rspSel) && $stable(rspErr));

  a_r8_accept_loads: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> rspValid);

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |-> !reqReady);

  a_r7_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    rspReady |-> reqReady);

  a_r7_err_clean: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr |-> (rspAddr == '0) && !rspSel);
endmodule

bind secdec_top secdec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .rspReady (rspReady),
  .rspSel   (rspSel),
  .rspErr   (rspErr),
  .rspAddr  (rspAddr)
);

// File: tb/secdec_top_bench.sv
`timescale 1ns/1ps
module secdec_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspReady = 1'b1;
  logic        rspSel;
  logic [31:0] rspAddr;
  logic        rspErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  secdec_top u_secdec_top (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspSel(rspSel),
    .rspAddr(rspAddr), .rspErr(rspErr)
  );

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic checkRsp(string tag, logic expErr, logic expSel, logic [31:0] expAddr);
    checks++;
    if (rspValid !== 1'b1 || rspErr !== expErr || rspSel !== expSel || rspAddr !== expAddr) begin
      fails++;
      $display("FAIL %s: got v=%0b err=%0b sel=%0b addr=%h expected v=1 err=%0b sel=%0b addr=%h",
               tag, rspValid, rspErr, rspSel, rspAddr, expErr, expSel, expAddr);
    end
  endtask

  task automatic writeSec(logic [1:0] idx, logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgIdx = idx; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // one request, consumed at once; result sampled the cycle after acceptance
  task automatic sendReq(string tag, logic [31:0] addr, logic expErr, logic expSel,
                         logic [31:0] expAddr);
    @(negedge clk);
    rspReady = 1'b1; reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp(tag, expErr, expSel, expAddr);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkBit("R1 rspValid low after reset", rspValid, 1'b0);
    checkBit("R1 reqReady high after reset", reqReady, 1'b1);
    sendReq("R1 empty map gives error", 32'h8000_0000, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic testCatchAll();
    writeSec(2'd0, 32'h8072_0100);   // 0x80, 2 GB, no intl, map 1, cbase 0
    writeSec(2'd3, 32'h8064_0300);   // 0x80, 1 GB, intl 128, map 3, cbase 0
    sendReq("R5 bit7 set -> ctrl1", 32'h8000_0080, 1'b0, 1'b1, 32'h0000_0000);
    sendReq("R5 bit7 clear -> ctrl0", 32'h8000_0100, 1'b0, 1'b0, 32'h0000_0080);
    sendReq("R5 offset compaction", 32'h8000_1234, 1'b0, 1'b0, 32'h0000_0934);
    sendReq("R4 beyond high section catch-all", 32'hC000_0000, 1'b0, 1'b0, 32'h4000_0000);
    sendReq("R10 top of 2GB window", 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h7FFF_FFFF);
    sendReq("R7 below windows", 32'h7FFF_FFFF, 1'b1, 1'b0, 32'h0);
    sendReq("R7 address zero", 32'h0000_0000, 1'b1, 1'b0, 32'h0);
  endtask

  task automatic testWindow();
    writeSec(2'd1, 32'h1000_0205);   // 0x10, 16 MB, map 2, cbase 0x05
    sendReq("R2 inside 16MB window", 32'h10AB_CDEF, 1'b0, 1'b1, 32'h05AB_CDEF);
    sendReq("R2 one past end", 32'h1100_0000, 1'b1, 1'b0, 32'h0);
    sendReq("R2 one below start", 32'h0FFF_FFFF, 1'b1, 1'b0, 32'h0);
    writeSec(2'd2, 32'h1000_0106);   // overlapping, map 1, cbase 0x06
    sendReq("R4 higher index wins", 32'h1000_0010, 1'b0, 1'b0, 32'h0600_0010);
    writeSec(2'd2, 32'h0000_0000);
    sendReq("R3 zeroed section disabled", 32'h1000_0010, 1'b0, 1'b1, 32'h0500_0010);
  endtask

  task automatic testMaps();
    writeSec(2'd2, 32'h2000_0000);   // map 0
    sendReq("R6 map 0 errors", 32'h2000_0004, 1'b1, 1'b0, 32'h0);
    writeSec(2'd2, 32'h2000_0300);   // map 3, no intl
    sendReq("R6 map 3 without intl", 32'h2000_0084, 1'b0, 1'b0, 32'h0000_0084);
    writeSec(2'd2, 32'h2004_0100);   // intl mode 1 but map 1
    sendReq("R6 intl with map 1 ignored", 32'h2000_0084, 1'b0, 1'b0, 32'h0000_0084);
  endtask

  task automatic testBackpressure();
    @(negedge clk);
    rspReady = 1'b0; reqValid = 1'b1; reqAddr = 32'h1000_0001;
    @(negedge clk);
    reqAddr = 32'h8000_0080;   // second request waits
    checkRsp("R8 first response", 1'b0, 1'b1, 32'h0500_0001);
    checkBit("R8 not ready while held", reqReady, 1'b0);
    cfgWe = 1'b1; cfgIdx = 2'd1; cfgData = 32'h1000_0209;
    @(negedge clk);
    cfgWe = 1'b0;
    checkRsp("R9 held response unchanged by write", 1'b0, 1'b1, 32'h0500_0001);
    @(negedge clk);
    checkRsp("R8 still held", 1'b0, 1'b1, 32'h0500_0001);
    rspReady = 1'b1;
    #1;
    checkBit("R8 ready while draining", reqReady, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    checkRsp("R8 second taken while draining", 1'b0, 1'b1, 32'h0000_0000);
    @(negedge clk);
    checkBit("R8 empty after drain", rspValid, 1'b0);
  endtask

  task automatic testWriteRace();
    @(negedge clk);
    rspReady = 1'b1; reqValid = 1'b1; reqAddr = 32'h1000_0020;
    cfgWe = 1'b1; cfgIdx = 2'd1; cfgData = 32'h1000_0207;
    @(negedge clk);
    cfgWe = 1'b0; reqValid = 1'b0;
    checkRsp("R9 same-cycle write uses old", 1'b0, 1'b1, 32'h0900_0020);
    sendReq("R9 later request sees write", 32'h1000_0020, 1'b0, 1'b1, 32'h0700_0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCatchAll();
    testWindow();
    testMaps();
    testBackpressure();
    testWriteRace();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule